// File: doc/BRIEF.md
# Programmable Display Timing Generator

This block produces the scan timing for one video output. Two counters walk across the frame: a pixel counter and a line counter. Both step only when the dot-clock enable pulses. From the counter positions the block derives horizontal and vertical sync, a horizontal active flag, a vertical active flag and a separate data-enable window. It also gates the incoming pixel colour to black wherever the beam is outside the visible area. Software sets every edge of these windows through a small write-only register port.

Horizontal positions are counted from the leading edge of HSYNC. The start and end of the active pixels carry a fixed offset of 19 dot clocks, which covers the pixel pipeline delay. Vertical positions are counted from the first line after vertical sync. The start and end of the active lines carry an offset of 2 lines, and the vertical sync position carries an offset of 1 line.

Timing values that are changed while the generator runs are held back until the frame wraps, so the frame in progress is never torn. A plane-enable word is double-buffered and is applied at the vertical blanking event. That same event sets a sticky frame-status bit, which software clears by writing one. The status bit drives an interrupt through an enable bit.

Top module: `disp_timing_gen`

## Requirements
- R1: The pixel counter runs from 0 to the value at address 0, and the line counter runs from 0 to the value at address 6, so a frame lasts (addr0+1)·(addr6+1) enabled dots. Neither counter moves on a cycle without `dot_en`.
- R2: The raw horizontal sync is active on pixels 0 through the value at address 1, a width of addr1+1 dots.
- R3: `hact_o` is high for pixels p with addr2+19 ≤ p < addr3+19.
- R4: `de_o` is high for pixels p with addr4 ≤ p < addr4+addr5, with no offset added.
- R5: `vact_o` is high for lines l with addr7+2 ≤ l < addr8+2. The raw vertical sync is active from line addr9+1 up to the last line of the frame.
- R6: Bit 1 of the control word at address 10 makes `hsync_o` active-low, and bit 2 makes `vsync_o` active-low. When the bit is clear, that sync output is active-high. A change takes effect at once.
- R7: Bit 0 of address 10 selects run mode. Entering run mode starts the scan at pixel 0 of line 0 and raises `sync_oe`. While stopped, `sync_oe` is low, the counters hold at zero, and every sync, enable and flag output is 0.
- R8: Writes to address 11 go to a shadow copy. `plane_en_o` loads that copy only at the vertical blanking event.
- R9: The vertical blanking event is the enabled dot that moves the scan to pixel 0 of line addr8+2. It sets `frame_status`, and writing 1 in bit 0 of address 12 clears it.
- R10: `irq` equals `frame_status` AND bit 0 of address 13.
- R11: `pix_out` equals `pix_in` when both `hact_o` and `vact_o` are high, and is 0 otherwise, including whenever the generator is stopped.
- R12: A write to addresses 0 to 9 while running takes effect when the scan wraps to pixel 0 of line 0. A write while stopped takes effect when run mode is entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| dot_en | input | 1 | Dot-clock enable; one scan step per pulse |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 12 | Register write data |
| pix_in | input | 24 | Incoming pixel colour |
| sync_oe | output | 1 | Sync outputs are driven (run mode) |
| hsync_o | output | 1 | Horizontal sync, polarity applied |
| vsync_o | output | 1 | Vertical sync, polarity applied |
| de_o | output | 1 | Data-enable window |
| hact_o | output | 1 | Horizontal active region |
| vact_o | output | 1 | Vertical active region |
| pix_out | output | 24 | Pixel colour, black outside the active area |
| plane_en_o | output | 8 | Live plane-enable word |
| frame_status | output | 1 | Sticky vertical blanking flag |
| irq | output | 1 | Frame interrupt |

## Verification
A counter that wraps at the wrong limit or steps without `dot_en` shifts every window edge. A sweep that predicts each output for every dot shows this within one line for pixel errors and within one frame for line errors. A timing copy that loads at the wrong moment appears as a sync width change partway through a frame, caught on the first line after the faulty write. A shadow or status bit that updates off the blanking event shows up on `plane_en_o`, `frame_status` and `irq` at the first sample after the wrong edge.

// File: rtl/dtg_pkg.sv
package dtg_pkg;

    localparam int TW     = 12;
    localparam int ADDR_W = 4;
    localparam int NUM_TF = 10;
    localparam int H_COMP = 19;
    localparam int V_COMP = 2;
    localparam int VS_OFS = 1;

    typedef enum logic [ADDR_W-1:0] {
        A_HTOT  = 4'd0,
        A_HSW   = 4'd1,
        A_HAS   = 4'd2,
        A_HAE   = 4'd3,
        A_DES   = 4'd4,
        A_DEW   = 4'd5,
        A_VTOT  = 4'd6,
        A_VAS   = 4'd7,
        A_VAE   = 4'd8,
        A_VSP   = 4'd9,
        A_CTRL  = 4'd10,
        A_PLANE = 4'd11,
        A_CLR   = 4'd12,
        A_IRQEN = 4'd13
    } reg_addr_e;

    typedef struct packed {
        logic [TW-1:0] htot;
        logic [TW-1:0] hsw;
        logic [TW-1:0] has;
        logic [TW-1:0] hae;
        logic [TW-1:0] des;
        logic [TW-1:0] dew;
        logic [TW-1:0] vtot;
        logic [TW-1:0] vas;
        logic [TW-1:0] vae;
        logic [TW-1:0] vsp;
    } timing_t;

    typedef struct packed {
        logic run;
        logic hlow;
        logic vlow;
    } ctrl_t;

    typedef struct packed {
        logic hsync;
        logic vsync;
        logic de;
        logic hact;
        logic vact;
    } scan_t;

    function automatic logic in_span(logic [TW:0] p, logic [TW:0] lo, logic [TW:0] hi);
        return (p >= lo) && (p < hi);
    endfunction

endpackage

// File: rtl/dtg_regfile.sv
module dtg_regfile
    import dtg_pkg::*;
#(
    parameter int PLANE_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [TW-1:0]      wr_data,
    output timing_t            prog,
    output ctrl_t              ctrl,
    output logic [PLANE_W-1:0] plane_shadow,
    output logic               irq_en,
    output logic               stat_clr
);

    logic [TW-1:0] tf [NUM_TF];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_TF; i++) tf[i] <= '0;
            ctrl         <= '0;
            plane_shadow <= '0;
            irq_en       <= 1'b0;
        end else if (wr_en) begin
            for (int i = 0; i < NUM_TF; i++)
                if (wr_addr == ADDR_W'(i)) tf[i] <= wr_data;
            if (wr_addr == A_CTRL)
                ctrl <= '{run: wr_data[0], hlow: wr_data[1], vlow: wr_data[2]};
            if (wr_addr == A_PLANE) plane_shadow <= wr_data[PLANE_W-1:0];
            if (wr_addr == A_IRQEN) irq_en <= wr_data[0];
        end
    end

    assign stat_clr = wr_en && (wr_addr == A_CLR) && wr_data[0];

    always_comb begin
        prog.htot = tf[A_HTOT];
        prog.hsw  = tf[A_HSW];
        prog.has  = tf[A_HAS];
        prog.hae  = tf[A_HAE];
        prog.des  = tf[A_DES];
        prog.dew  = tf[A_DEW];
        prog.vtot = tf[A_VTOT];
        prog.vas  = tf[A_VAS];
        prog.vae  = tf[A_VAE];
        prog.vsp  = tf[A_VSP];
    end

endmodule

// File: rtl/dtg_scan_counter.sv
module dtg_scan_counter
    import dtg_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          dot_en,
    input  logic [TW-1:0] htot,
    input  logic [TW-1:0] vtot,
    output logic [TW-1:0] hc,
    output logic [TW-1:0] vc,
    output logic          h_last,
    output logic          v_last
);

    assign h_last = (hc == htot);
    assign v_last = (vc == vtot);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            hc <= '0;
            vc <= '0;
        end else if (dot_en) begin
            if (h_last) begin
                hc <= '0;
                vc <= v_last ? '0 : vc + 1'b1;
            end else begin
                hc <= hc + 1'b1;
            end
        end
    end

endmodule

// File: rtl/dtg_window.sv
module dtg_window
    import dtg_pkg::*;
(
    input  logic [TW-1:0] hc,
    input  logic [TW-1:0] vc,
    input  timing_t       tm,
    output scan_t         sc
);

    localparam int TX = TW + 1;

    logic [TX-1:0] hpos, vpos;

    assign hpos = {1'b0, hc};
    assign vpos = {1'b0, vc};

    always_comb begin
        sc.hsync = hpos <= {1'b0, tm.hsw};
        sc.hact  = in_span(hpos, {1'b0, tm.has} + TX'(H_COMP),
                                 {1'b0, tm.hae} + TX'(H_COMP));
        sc.de    = in_span(hpos, {1'b0, tm.des}, {1'b0, tm.des} + {1'b0, tm.dew});
        sc.vact  = in_span(vpos, {1'b0, tm.vas} + TX'(V_COMP),
                                 {1'b0, tm.vae} + TX'(V_COMP));
        sc.vsync = vpos >= ({1'b0, tm.vsp} + TX'(VS_OFS));
    end

endmodule

// File: rtl/disp_timing_gen.sv
module disp_timing_gen
    import dtg_pkg::*;
#(
    parameter int PIX_W   = 24,
    parameter int PLANE_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               dot_en,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [TW-1:0]      wr_data,
    input  logic [PIX_W-1:0]   pix_in,
    output logic               sync_oe,
    output logic               hsync_o,
    output logic               vsync_o,
    output logic               de_o,
    output logic               hact_o,
    output logic               vact_o,
    output logic [PIX_W-1:0]   pix_out,
    output logic [PLANE_W-1:0] plane_en_o,
    output logic               frame_status,
    output logic               irq
);

    localparam int TX = TW + 1;

    timing_t            prog, act_tm;
    ctrl_t              ctrl;
    logic [PLANE_W-1:0] plane_shadow;
    logic               irq_en, stat_clr;
    logic [TW-1:0]      hc, vc;
    logic               h_last, v_last;
    scan_t              sc;
    logic [TX-1:0]      blank_line, v_next;
    logic               frame_evt, frame_wrap;

    dtg_regfile #(.PLANE_W(PLANE_W)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .prog(prog), .ctrl(ctrl), .plane_shadow(plane_shadow),
        .irq_en(irq_en), .stat_clr(stat_clr)
    );

    dtg_scan_counter u_cnt (
        .clk(clk), .rst(rst), .run(ctrl.run), .dot_en(dot_en),
        .htot(act_tm.htot), .vtot(act_tm.vtot),
        .hc(hc), .vc(vc), .h_last(h_last), .v_last(v_last)
    );

    dtg_window u_win (.hc(hc), .vc(vc), .tm(act_tm), .sc(sc));

    assign blank_line = {1'b0, act_tm.vae} + TX'(V_COMP);
    assign v_next     = v_last ? '0 : {1'b0, vc} + 1'b1;
    assign frame_evt  = ctrl.run && dot_en && h_last && (v_next == blank_line);
    assign frame_wrap = ctrl.run && dot_en && h_last && v_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_tm       <= '0;
            frame_status <= 1'b0;
            plane_en_o   <= '0;
        end else begin
            if (!ctrl.run || frame_wrap) act_tm <= prog;
            if (frame_evt)     frame_status <= 1'b1;
            else if (stat_clr) frame_status <= 1'b0;
            if (frame_evt) plane_en_o <= plane_shadow;
        end
    end

    assign sync_oe = ctrl.run;
    assign hsync_o = ctrl.run && (sc.hsync ^ ctrl.hlow);
    assign vsync_o = ctrl.run && (sc.vsync ^ ctrl.vlow);
    assign de_o    = ctrl.run && sc.de;
    assign hact_o  = ctrl.run && sc.hact;
    assign vact_o  = ctrl.run && sc.vact;
    assign pix_out = (hact_o && vact_o) ? pix_in : '0;
    assign irq     = frame_status && irq_en;

endmodule

// File: rtl/dtg_checker.sv
module dtg_checker
    import dtg_pkg::*;
#(
    parameter int PIX_W   = 24,
    parameter int PLANE_W = 8
) (
    input logic               clk,
    input logic               rst,
    input logic               dot_en,
    input logic               wr_en,
    input logic               sync_oe,
    input logic               hsync_o,
    input logic               vsync_o,
    input logic               de_o,
    input logic [PIX_W-1:0]   pix_out,
    input logic [PLANE_W-1:0] plane_en_o,
    input logic               frame_status,
    input logic               irq,
    input logic [TW-1:0]      hc,
    input logic [TW-1:0]      vc,
    input logic [TW-1:0]      act_htot,
    input logic               frame_evt
);

    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        !sync_oe |-> (pix_out == '0) && !de_o && !hsync_o && !vsync_o);

    assert_pix_bound_R1: assert property (@(posedge clk) disable iff (rst)
        hc <= act_htot);

    assert_dot_stall_R1: assert property (@(posedge clk) disable iff (rst)
        (sync_oe && !dot_en && !wr_en) |=> $stable(hc) && $stable(vc));

    assert_plane_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !frame_evt |=> $stable(plane_en_o));

    assert_status_source_R9: assert property (@(posedge clk) disable iff (rst)
        (!frame_evt && !frame_status) |=> !frame_status);

    assert_irq_gate_R10: assert property (@(posedge clk) disable iff (rst)
        irq |-> frame_status);

endmodule

bind disp_timing_gen dtg_checker #(.PIX_W(PIX_W), .PLANE_W(PLANE_W)) u_chk (
    .clk(clk), .rst(rst), .dot_en(dot_en), .wr_en(wr_en), .sync_oe(sync_oe),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o), .pix_out(pix_out),
    .plane_en_o(plane_en_o), .frame_status(frame_status), .irq(irq),
    .hc(hc), .vc(vc), .act_htot(act_tm.htot), .frame_evt(frame_evt)
);

// File: tb/test_disp_timing_gen.sv
`timescale 1ns/1ps
module test_disp_timing_gen;

    localparam int TW  = 12;
    localparam int PIX = 24'hABCDEF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        dot_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [TW-1:0] wr_data = '0;
    logic [23:0] pix_in = 24'hABCDEF;
    logic        sync_oe, hsync_o, vsync_o, de_o, hact_o, vact_o;
    logic [23:0] pix_out;
    logic [7:0]  plane_en_o;
    logic        frame_status, irq;

    always #2 clk = ~clk;

    disp_timing_gen i_disp_timing_gen (
        .clk(clk), .rst(rst), .dot_en(dot_en), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pix_in(pix_in), .sync_oe(sync_oe), .hsync_o(hsync_o),
        .vsync_o(vsync_o), .de_o(de_o), .hact_o(hact_o), .vact_o(vact_o),
        .pix_out(pix_out), .plane_en_o(plane_en_o), .frame_status(frame_status),
        .irq(irq)
    );

    int checks = 0, fails = 0;
    bit done = 0;
    int bh = 0, bv = 0;
    int pend[10], act[10];
    bit run_b = 0, hlow_b = 0, vlow_b = 0, stat_b = 0, irqen_b = 0;
    int shadow_b = 0, plane_b = 0;

    task automatic chk(string tag, int got, int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h (pixel %0d line %0d)", tag, got, exp, bh, bv);
        end
    endtask

    task automatic check_all();
        int hs = 0, vs = 0, ha = 0, va = 0, de = 0, px = 0;
        if (run_b) begin
            hs = int'(bh <= act[1]) ^ int'(hlow_b);
            vs = int'(bv >= act[9] + 1) ^ int'(vlow_b);
            ha = int'(bh >= act[2] + 19 && bh < act[3] + 19);
            de = int'(bh >= act[4] && bh < act[4] + act[5]);
            va = int'(bv >= act[7] + 2 && bv < act[8] + 2);
            px = (ha != 0 && va != 0) ? PIX : 0;
        end
        chk("R7 sync_oe", int'(sync_oe), int'(run_b));
        chk("R2 R6 hsync", int'(hsync_o), hs);
        chk("R5 R6 vsync", int'(vsync_o), vs);
        chk("R3 hact", int'(hact_o), ha);
        chk("R4 de", int'(de_o), de);
        chk("R5 vact", int'(vact_o), va);
        chk("R11 pix", int'(pix_out), px);
        chk("R8 plane", int'(plane_en_o), plane_b);
        chk("R9 status", int'(frame_status), int'(stat_b));
        chk("R10 irq", int'(irq), int'(stat_b && irqen_b));
    endtask

    task automatic wr(int a, int d);
        bit prev;
        wr_en = 1'b1; wr_addr = 4'(a); wr_data = TW'(d); dot_en = 1'b0;
        @(negedge clk);
        wr_en = 1'b0;
        if (a < 10) begin
            pend[a] = d;
            if (!run_b) act[a] = d;
        end else if (a == 10) begin
            prev = run_b;
            run_b = d[0]; hlow_b = d[1]; vlow_b = d[2];
            if (!run_b || !prev) begin
                bh = 0; bv = 0;
                for (int i = 0; i < 10; i++) act[i] = pend[i];
            end
        end else if (a == 11) shadow_b = d;
        else if (a == 12) begin
            if (d[0]) stat_b = 0;
        end else if (a == 13) irqen_b = d[0];
    endtask

    task automatic step(bit e);
        check_all();
        dot_en = e;
        @(negedge clk);
        dot_en = 1'b0;
        if (e && run_b) begin
            if (bh == act[0]) begin
                bh = 0;
                if (bv == act[6]) bv = 0; else bv++;
            end else bh++;
            if (bh == 0 && bv == act[8] + 2) begin   // R9 blanking event, R8 shadow load
                stat_b = 1; plane_b = shadow_b;
            end
            if (bh == 0 && bv == 0)                  // R12 frame-start reload
                for (int i = 0; i < 10; i++) act[i] = pend[i];
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 10; i++) begin pend[i] = 0; act[i] = 0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check_all();                               // R7 reset state
        wr(0, 39); wr(1, 3); wr(2, 2); wr(3, 14); wr(4, 20);
        wr(5, 12); wr(6, 9); wr(7, 0); wr(8, 5); wr(9, 7);
        wr(13, 1);
        wr(11, 8'h5A);
        check_all();                               // R8 shadow not live yet
        wr(10, 1);                                 // R7 run entry
        for (int i = 0; i < 420; i++) step(1);     // R1..R5 full frame
        wr(12, 1);                                 // R9 clear
        check_all();
        wr(10, 7);                                 // R6 both active-low
        for (int i = 0; i < 100; i++) begin step(1); step(0); step(0); end  // R1 stall
        wr(1, 7);                                  // R12 deferred width change
        wr(11, 0);                                 // R8 zero from next frame
        for (int i = 0; i < 400; i++) begin step(1); step(0); end
        wr(13, 0);                                 // R10 enable off
        for (int i = 0; i < 400; i++) step(1);
        wr(10, 6);                                 // R7 stop
        for (int i = 0; i < 20; i++) step(1);
        wr(4, 22);                                 // R12 write while stopped
        wr(10, 1);                                 // R7 restart at origin
        for (int i = 0; i < 60; i++) step(1);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule